// File: doc/BRIEF.md
# Sized Integer ALU with Status Flags

This block is a purely combinational arithmetic and logic unit for a 32-bit datapath. It takes a destination operand and a source operand, an operation code, a size code and a destination-kind bit. It returns a result and four status flags: carry, zero, sign and overflow. The operations are add, subtract, three bitwise operations, a non-writing bit test, three shifts and two rotates. Shift and rotate amounts come from the low five bits of the source operand.

Each operation works on an effective field. When the destination is memory, the size code picks an 8-, 16- or 32-bit field. When the destination is a register, the field is always the full 32 bits. Every flag is judged at the top bit of that field, and the zero test covers only the field. Bits of the result above the field are driven to zero, so the consumer stores only the field.

Top module: `sized_alu`

## Requirements
- R1: The field width is 32 when `to_mem_i` is 0. When `to_mem_i` is 1 it is 8 for size code 00, 16 for 01, and 32 for 10 or 11. Result bits above the field are always 0.
- R2: Op code 0 (add) gives (a+b) mod 2^W. Op code 1 (subtract) gives (a-b) mod 2^W, where a is the destination operand and W is the field width.
- R3: For add, carry is 1 when the sum carries out of field bit W-1. For subtract, carry is 1 when the unsigned field value of a is below that of b.
- R4: For add and subtract, overflow is 1 exactly when the signed W-bit result differs from the true signed sum or difference.
- R5: Zero is 1 when the flag value's low W bits are all 0. Sign equals bit W-1 of the flag value. The flag value is the result, except for the bit test (R7).
- R6: Op codes 2, 3 and 4 give a AND b, a OR b and a XOR b within the field. Carry and overflow are 0.
- R7: Op code 5 (bit test) drives the sized a as the result. Zero and sign are taken from a AND b. Carry and overflow are 0.
- R8: With count n = b[4:0] > 0, op code 6 shifts left and op code 8 shifts right logically within the field, filling with 0. Op code 7 shifts right and fills with field bit W-1. Carry is the last bit shifted out, and the count ignores b[31:5].
- R9: Op code 9 rotates left and op code 10 rotates right within the field by n mod W. Carry is the bit moved across the field edge on the last single step: the new lsb for a left rotate, the new field msb for a right rotate.
- R10: For op codes 6 to 10 with n > 0, overflow is 1 exactly when field bit W-1 differs before and after the last single-bit step. It is therefore always 0 for op code 7.
- R11: For op codes 6 to 10 with n = 0, the result is the sized a. Carry and overflow are 0.
- R12: Op codes 11 to 15 give the sized a as the result, with all four flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (R2 to R12) |
| size_i | input | 2 | Field size code for memory destinations |
| to_mem_i | input | 1 | 1 = memory destination, 0 = register destination |
| a_i | input | 32 | Destination operand |
| b_i | input | 32 | Source operand; bits 4:0 give the shift count |
| result_o | output | 32 | Sized result, zero above the field |
| carry_o | output | 1 | Carry / borrow / last bit shifted out |
| zero_o | output | 1 | Field of flag value is all zeros |
| sign_o | output | 1 | Field msb of flag value |
| ovf_o | output | 1 | Signed overflow / sign change on last shift step |

## Verification
The sweep targets three kinds of error. The first is field boundaries: operands such as 0x7F, 0x80, 0x8000 and 0x80000000 under every size code and both destination kinds. A design that judges flags at bit 31 for a byte memory destination, or at bit 7 for a register destination, gives the wrong carry, sign and zero there. The second is shift counts from 0 to 31 against 8- and 16-bit fields. Counts past the field width expose a shifter that leaks bits above the field or mis-takes the carry. Rotates by a multiple of the width expose a wrong modulo. A reference that steps one bit at a time catches overflow taken from any step other than the last. The third is the zero count, the non-writing bit test and the reserved codes, where a careless design leaves a stale carry or overwrites the destination.

// File: rtl/sized_alu_pkg.sv
package sized_alu_pkg;

    localparam int DATA_W = 32;
    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;
    localparam int CNT_W  = $clog2(DATA_W);

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [CNT_W:0]    wid_t;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_TEST = 4'd5,
        OP_SHL  = 4'd6,
        OP_SAR  = 4'd7,
        OP_SHR  = 4'd8,
        OP_ROL  = 4'd9,
        OP_ROR  = 4'd10,
        OP_R11  = 4'd11,
        OP_R12  = 4'd12,
        OP_R13  = 4'd13,
        OP_R14  = 4'd14,
        OP_R15  = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_FULL = 2'b10,
        SZ_RSVD = 2'b11
    } alu_size_e;

    // Effective field of one operation
    typedef struct packed {
        word_t mask;
        cnt_t  msb;
        wid_t  width;
    } field_t;

    typedef struct packed {
        logic carry;
        logic zero;
        logic sign;
        logic ovf;
    } alu_flags_t;

    // Register destinations always use the whole word
    function automatic field_t field_of(input alu_size_e sz, input logic to_mem);
        field_t f;
        int     w;
        if (!to_mem) begin
            w = DATA_W;
        end else begin
            case (sz)
                SZ_BYTE: w = BYTE_W;
                SZ_HALF: w = HALF_W;
                default: w = DATA_W;
            endcase
        end
        f.width = wid_t'(w);
        f.msb   = cnt_t'(w - 1);
        f.mask  = (w >= DATA_W) ? '1 : ((word_t'(1) << w) - word_t'(1));
        return f;
    endfunction

    function automatic logic is_shift_op(input alu_op_e op);
        return (op == OP_SHL) || (op == OP_SAR) || (op == OP_SHR) ||
               (op == OP_ROL) || (op == OP_ROR);
    endfunction

    function automatic logic is_logic_op(input alu_op_e op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_TEST);
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import sized_alu_pkg::*;
(
    input  alu_op_e op,
    input  field_t  fld,
    input  word_t   a,
    input  word_t   b,
    output word_t   res,
    output logic    carry,
    output logic    ovf
);
    logic [DATA_W:0] wide;
    word_t           am;
    word_t           bm;
    logic            sa;
    logic            sb;
    logic            sr;
    logic            is_sub;

    always_comb begin
        am     = a & fld.mask;
        bm     = b & fld.mask;
        is_sub = (op == OP_SUB);
        if (is_sub) begin
            wide = {1'b0, am} - {1'b0, bm};
        end else begin
            wide = {1'b0, am} + {1'b0, bm};
        end
        res   = wide[DATA_W-1:0] & fld.mask;
        // bit just above the field: carry out on add, borrow on subtract
        carry = wide[fld.width];
        sa    = am[fld.msb];
        sb    = bm[fld.msb];
        sr    = res[fld.msb];
        if (is_sub) begin
            ovf = (sa != sb) && (sr == sb);
        end else begin
            ovf = (sa == sb) && (sr != sa);
        end

        if (is_sub) begin
            assert_borrow_R3: assert (carry == (am < bm))
                else $error("subtract borrow disagrees with operand compare");
        end else begin
            assert_carry_R3: assert (carry == (res < am))
                else $error("add carry disagrees with wrap of sum");
        end
    end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import sized_alu_pkg::*;
(
    input  alu_op_e op,
    input  word_t   mask,
    input  word_t   a,
    input  word_t   b,
    output word_t   res,
    output word_t   flag_val,
    output logic    carry,
    output logic    ovf
);
    word_t val;

    always_comb begin
        case (op)
            OP_OR:   val = a | b;
            OP_XOR:  val = a ^ b;
            default: val = a & b;
        endcase
        flag_val = val & mask;
        // bit test leaves the destination as it was
        res      = (op == OP_TEST) ? (a & mask) : flag_val;
        carry    = 1'b0;
        ovf      = 1'b0;

        if (op == OP_TEST) begin
            assert_test_keeps_dest_R7: assert (((res ^ a) & mask) == '0)
                else $error("bit test altered the destination field");
        end
    end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
    import sized_alu_pkg::*;
(
    input  alu_op_e op,
    input  field_t  fld,
    input  word_t   a,
    input  cnt_t    cnt,
    output word_t   res,
    output logic    carry,
    output logic    ovf
);
    // Shift or rotate a sized value by n steps inside the field
    function automatic word_t move(input word_t x, input cnt_t n, input alu_op_e o,
                                   input field_t f);
        word_t r;
        word_t sx;
        int    k;
        k = int'(n) % int'(f.width);
        case (o)
            OP_SHL: r = x << n;
            OP_SHR: r = x >> n;
            OP_SAR: begin
                sx = x | (x[f.msb] ? ~f.mask : '0);
                r  = word_t'($signed(sx) >>> n);
            end
            OP_ROL: r = (k == 0) ? x : ((x << k) | (x >> (int'(f.width) - k)));
            OP_ROR: r = (k == 0) ? x : ((x >> k) | (x << (int'(f.width) - k)));
            default: r = x;
        endcase
        return r & f.mask;
    endfunction

    word_t xm;
    word_t fin;
    word_t prev;
    logic  leftward;

    always_comb begin
        xm       = a & fld.mask;
        fin      = move(xm, cnt, op, fld);
        prev     = move(xm, cnt - cnt_t'(1), op, fld);
        leftward = (op == OP_SHL) || (op == OP_ROL);
        if (cnt == '0) begin
            res   = xm;
            carry = 1'b0;
            ovf   = 1'b0;
        end else begin
            res   = fin;
            carry = leftward ? prev[fld.msb] : prev[0];
            ovf   = prev[fld.msb] ^ fin[fld.msb];
        end

        if (op == OP_SAR) begin
            assert_sar_no_ovf_R10: assert (!ovf)
                else $error("arithmetic right shift changed the sign");
        end
        if ((op == OP_ROL) || (op == OP_ROR)) begin
            assert_rotate_keeps_bits_R9: assert ($countones(res) == $countones(xm))
                else $error("rotate lost or created bits");
        end
    end

endmodule

// File: rtl/alu_status.sv
module alu_status
    import sized_alu_pkg::*;
(
    input  word_t mask,
    input  cnt_t  msb,
    input  word_t flag_val,
    output logic  zero,
    output logic  sign
);
    always_comb begin
        zero = ((flag_val & mask) == '0);
        sign = flag_val[msb];
        assert_zero_not_negative_R5: assert (!(zero && sign))
            else $error("zero and sign both set");
    end

endmodule

// File: rtl/sized_alu.sv
module sized_alu
    import sized_alu_pkg::*;
(
    input  logic [3:0]        op_i,
    input  logic [1:0]        size_i,
    input  logic              to_mem_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] result_o,
    output logic              carry_o,
    output logic              zero_o,
    output logic              sign_o,
    output logic              ovf_o
);
    alu_op_e    op;
    field_t     fld;

    word_t      as_res;
    logic       as_c;
    logic       as_v;
    word_t      lg_res;
    word_t      lg_val;
    logic       lg_c;
    logic       lg_v;
    word_t      sh_res;
    logic       sh_c;
    logic       sh_v;
    word_t      flag_val;
    logic       st_zero;
    logic       st_sign;
    logic       reserved;
    alu_flags_t fl;

    assign op  = alu_op_e'(op_i);
    assign fld = field_of(alu_size_e'(size_i), to_mem_i);

    alu_addsub u_addsub (
        .op    (op),
        .fld   (fld),
        .a     (a_i),
        .b     (b_i),
        .res   (as_res),
        .carry (as_c),
        .ovf   (as_v)
    );

    alu_logic u_logic (
        .op       (op),
        .mask     (fld.mask),
        .a        (a_i),
        .b        (b_i),
        .res      (lg_res),
        .flag_val (lg_val),
        .carry    (lg_c),
        .ovf      (lg_v)
    );

    alu_shifter u_shifter (
        .op    (op),
        .fld   (fld),
        .a     (a_i),
        .cnt   (b_i[CNT_W-1:0]),
        .res   (sh_res),
        .carry (sh_c),
        .ovf   (sh_v)
    );

    alu_status u_status (
        .mask     (fld.mask),
        .msb      (fld.msb),
        .flag_val (flag_val),
        .zero     (st_zero),
        .sign     (st_sign)
    );

    // Pick the flag value before the status unit sees it
    always_comb begin
        if ((op == OP_ADD) || (op == OP_SUB)) begin
            flag_val = as_res;
        end else if (is_logic_op(op)) begin
            flag_val = lg_val;
        end else if (is_shift_op(op)) begin
            flag_val = sh_res;
        end else begin
            flag_val = '0;
        end
    end

    always_comb begin
        reserved = 1'b0;
        fl.zero  = st_zero;
        fl.sign  = st_sign;
        if ((op == OP_ADD) || (op == OP_SUB)) begin
            result_o = as_res;
            fl.carry = as_c;
            fl.ovf   = as_v;
        end else if (is_logic_op(op)) begin
            result_o = lg_res;
            fl.carry = lg_c;
            fl.ovf   = lg_v;
        end else if (is_shift_op(op)) begin
            result_o = sh_res;
            fl.carry = sh_c;
            fl.ovf   = sh_v;
        end else begin
            reserved = 1'b1;
            result_o = a_i & fld.mask;
            fl       = '0;
        end
        carry_o = fl.carry;
        zero_o  = fl.zero;
        sign_o  = fl.sign;
        ovf_o   = fl.ovf;

        assert_upper_clear_R1: assert ((result_o & ~fld.mask) == '0)
            else $error("result bits above the field are set");
        if (is_logic_op(op)) begin
            assert_logic_clears_R6: assert (!carry_o && !ovf_o)
                else $error("logical operation left carry or overflow set");
        end
        if (reserved) begin
            assert_reserved_quiet_R12: assert ({carry_o, zero_o, sign_o, ovf_o} == 4'b0000)
                else $error("reserved code raised a flag");
        end
    end

endmodule

// File: tb/tb_sized_alu.sv
module tb_sized_alu;

    logic        clk = 1'b0;
    logic [3:0]  op_i;
    logic [1:0]  size_i;
    logic        to_mem_i;
    logic [31:0] a_i;
    logic [31:0] b_i;
    logic [31:0] result_o;
    logic        carry_o;
    logic        zero_o;
    logic        sign_o;
    logic        ovf_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    sized_alu dut (
        .op_i     (op_i),
        .size_i   (size_i),
        .to_mem_i (to_mem_i),
        .a_i      (a_i),
        .b_i      (b_i),
        .result_o (result_o),
        .carry_o  (carry_o),
        .zero_o   (zero_o),
        .sign_o   (sign_o),
        .ovf_o    (ovf_o)
    );

    logic [31:0] pool [16] = '{32'h0, 32'h1, 32'h7F, 32'h80, 32'hFF, 32'h7FFF, 32'h8000,
                               32'hFFFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF,
                               32'h1234_5678, 32'hA5A5_C3F0, 32'h0000_FF80,
                               32'h0080_7F01, 32'hFEDC_BA98};

    task automatic check(input string tag, input string what,
                         input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s op=%0d size=%0d mem=%0d a=%h b=%h actual=%h expected=%h",
                     tag, what, op_i, size_i, to_mem_i, a_i, b_i, act, exp);
        end
    endtask

    function automatic longint signed sval(input longint unsigned x, input int w);
        if (((x >> (w - 1)) & 1) != 0) return longint'(x) - (longint'(1) << w);
        return longint'(x);
    endfunction

    task automatic run_one(input int op, input int sz, input int mem,
                           input logic [31:0] a, input logic [31:0] b);
        int w;
        longint unsigned mask, msbbit, am, bm, x, fv, er;
        longint signed   t, lo, hi;
        bit ec, ev, prevmsb, bitout;
        int n;
        string tr, tc, tv;

        w = (mem == 0) ? 32 : (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
        mask   = (longint'(1) << w) - 1;
        msbbit = longint'(1) << (w - 1);
        am = longint'(a) & mask;
        bm = longint'(b) & mask;
        n  = int'(b[4:0]);
        ec = 0; ev = 0; er = 0; fv = 0;
        lo = -(longint'(1) << (w - 1));
        hi = (longint'(1) << (w - 1)) - 1;
        tr = "R12"; tc = "R12"; tv = "R12";
        case (op)
            0: begin
                er = (am + bm) & mask; ec = ((am + bm) >> w) != 0;
                t = sval(am, w) + sval(bm, w); ev = (t < lo) || (t > hi);
                fv = er; tr = "R2"; tc = "R3"; tv = "R4";
            end
            1: begin
                er = (am - bm) & mask; ec = am < bm;
                t = sval(am, w) - sval(bm, w); ev = (t < lo) || (t > hi);
                fv = er; tr = "R2"; tc = "R3"; tv = "R4";
            end
            2, 3, 4: begin
                er = (op == 2) ? (am & bm) : (op == 3) ? (am | bm) : (am ^ bm);
                fv = er; tr = "R6"; tc = "R6"; tv = "R6";
            end
            5: begin
                er = am; fv = am & bm; tr = "R7"; tc = "R7"; tv = "R7";
            end
            6, 7, 8, 9, 10: begin
                x = am;
                prevmsb = 0;
                for (int i = 0; i < n; i++) begin
                    prevmsb = (x & msbbit) != 0;
                    case (op)
                        6: begin bitout = prevmsb; x = (x << 1) & mask; end
                        7: begin bitout = x[0]; x = (x >> 1) | (x & msbbit); end
                        8: begin bitout = x[0]; x = x >> 1; end
                        9: begin bitout = prevmsb; x = ((x << 1) & mask) | longint'(bitout); end
                        default: begin bitout = x[0]; x = (x >> 1) | (bitout ? msbbit : 0); end
                    endcase
                    ec = bitout;
                    ev = prevmsb != ((x & msbbit) != 0);
                end
                er = x; fv = x;
                if (n == 0) begin
                    tr = "R11"; tc = "R11"; tv = "R11";
                end else begin
                    tr = (op >= 9) ? "R9" : "R8"; tc = tr; tv = "R10";
                end
            end
            default: begin
                er = am; fv = 0;
            end
        endcase

        op_i = 4'(op); size_i = 2'(sz); to_mem_i = 1'(mem); a_i = a; b_i = b;
        #1;
        check(tr, "result", longint'(result_o), er);
        check("R1", "upper", longint'(result_o) & ~mask & 64'hFFFF_FFFF, 0);
        check(tc, "carry", longint'(carry_o), longint'(ec));
        check(tv, "ovf", longint'(ovf_o), longint'(ev));
        if (op <= 10) begin
            check("R5", "zero", longint'(zero_o), longint'((fv & mask) == 0));
            check("R5", "sign", longint'(sign_o), longint'((fv & msbbit) != 0));
        end else begin
            check("R12", "zero", longint'(zero_o), 0);
            check("R12", "sign", longint'(sign_o), 0);
        end
        #1;
    endtask

    initial begin
        op_i = 0; size_i = 0; to_mem_i = 0; a_i = 0; b_i = 0;
        #1;
        // idle state: add of zeros
        check("R1", "idle result", longint'(result_o), 0);
        check("R5", "idle zero", longint'(zero_o), 1);
        for (int op = 0; op < 16; op++) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int mem = 0; mem < 2; mem++) begin
                    for (int ai = 0; ai < 16; ai++) begin
                        if (op >= 6 && op <= 10) begin
                            for (int c = 0; c < 32; c++)   // R8: b[31:5] is junk
                                run_one(op, sz, mem, pool[ai], {pool[(ai + c) % 16][31:5], 5'(c)});
                        end else begin
                            for (int bi = 0; bi < 16; bi++)
                                run_one(op, sz, mem, pool[ai], pool[bi]);
                        end
                    end
                end
            end
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule